// File: doc/BRIEF.md
# Unified Tracking Table with Class-Priority Replacement

This block is a set-associative table that remembers where cache blocks currently live on a tiled multiprocessor. Each entry holds a block tag, a host tile number, a sharer bit vector and a class bit. The class bit says whether the entry is the home copy of the pointer (principal) or a local shortcut cached by a requesting tile (replicated). Both classes share one array. On a lookup the block answers with hit, class, host and sharers. On an insert it places the entry in the addressed set.

Replacement is not plain LRU. When a principal entry must be placed, it takes an empty way if one exists, then the least recent replicated way, and only as a last resort the least recent principal way. Displacing a principal entry is reported on an eviction output, so that the surrounding logic can invalidate the tracked block and every replicated copy named by the sharer vector. A replicated insert may only use empty or replicated ways. If there are none, the insert is dropped.

A request is taken in state IDLE when `req_valid` is high. The next edge moves to LOOKUP (when `req_op`=0) or INSERT (when `req_op`=1). That state updates the table and registers the response, then moves to DONE. In DONE `rsp_valid` is high for exactly one cycle, and the machine returns to IDLE. The address splits as {tag, set}, with the set index in the low bits.

Top module: `trk_table`

## Requirements
- R1: A lookup accepted at edge N presents `rsp_valid` for one cycle after edge N+1. On a match with a valid entry of the set it gives `rsp_hit`=1 with that entry's class (`rsp_principal`=1 for principal), host and sharers. On no match it gives `rsp_hit`=0. A lookup never reports stored or eviction, and `req_ready` is low from acceptance until the response has been shown.
- R2: An insert whose tag misses, in a set with at least one invalid way, takes the lowest-numbered invalid way. It reports `rsp_stored`=1, `rsp_hit`=0 and no eviction, whatever its class.
- R3: A principal insert into a full set that holds any replicated way replaces the least recently used replicated way, even if older principal ways exist. It raises no `evict_valid`.
- R4: A principal insert into a full set of principal ways replaces the least recently used principal way. It raises `evict_valid` with the victim's address {tag, set}, host and sharers in the response cycle.
- R5: A replicated insert into a full set with no replicated way is dropped. It reports `rsp_stored`=0 and no eviction, and it leaves contents and recency unchanged. A replicated insert never causes `evict_valid`.
- R6: A replicated insert into a full set that holds replicated ways replaces the least recently used replicated way, with no `evict_valid`.
- R7: A lookup hit and every stored insert make the touched way the most recent in its set. A lookup miss and a dropped insert change no recency.
- R8: An insert whose tag already matches a valid way rewrites that way's class, host and sharers in place. It reports `rsp_hit`=1, `rsp_stored`=1 and no eviction.
- R9: After reset the table is empty, `req_ready`=1 and `rsp_valid`=`evict_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge |
| req_op | input | 1 | 0 lookup, 1 insert |
| req_addr | input | TAG_W+SET_W | Block address {tag, set} |
| req_principal | input | 1 | Insert class: 1 principal, 0 replicated |
| req_host | input | log2(TILES) | Host tile for insert |
| req_sharers | input | TILES | Sharer vector for insert |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Tag matched a valid way |
| rsp_stored | output | 1 | Insert written to the table |
| rsp_principal | output | 1 | Class of the matched entry (lookup) |
| rsp_host | output | log2(TILES) | Host of the matched entry (lookup) |
| rsp_sharers | output | TILES | Sharers of the matched entry (lookup) |
| evict_valid | output | 1 | A principal entry was displaced |
| evict_addr | output | TAG_W+SET_W | Address of the displaced principal entry |
| evict_host | output | log2(TILES) | Host of the displaced entry |
| evict_sharers | output | TILES | Tiles whose replicated copies must be invalidated |

## Verification
The assertions assume that a request is offered only while `req_ready` is high. They also assume that the surrounding logic never keeps two valid entries with the same tag in one set, so a response always belongs to the single request in flight. The stimulus issues one request, waits for `req_ready` to return, and only then issues the next. It builds each set through inserts, and an insert with a tag already present updates in place and never adds a duplicate.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_INSERT = 2'd2,
        ST_DONE   = 2'd3
    } trk_state_e;
endpackage

// File: rtl/trk_store.sv
module trk_store #(
    parameter int SETS   = 32,
    parameter int WAYS   = 8,
    parameter int TAG_W  = 22,
    parameter int HOST_W = 4,
    parameter int TILES  = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0]              row_valid,
    output logic [WAYS-1:0]              row_prin,
    output logic [WAYS-1:0][TAG_W-1:0]   row_tag,
    output logic [WAYS-1:0][HOST_W-1:0]  row_host,
    output logic [WAYS-1:0][TILES-1:0]   row_shr,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_prin,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [HOST_W-1:0]            wr_host,
    input  logic [TILES-1:0]             wr_shr
);
    logic              valid_q [SETS][WAYS];
    logic              prin_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [HOST_W-1:0] host_q  [SETS][WAYS];
    logic [TILES-1:0]  shr_q   [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            prin_q[wr_set][wr_way] <= wr_prin;
            tag_q[wr_set][wr_way]  <= wr_tag;
            host_q[wr_set][wr_way] <= wr_host;
            shr_q[wr_set][wr_way]  <= wr_shr;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_valid[w] = valid_q[rd_set][w];
            row_prin[w]  = prin_q[rd_set][w];
            row_tag[w]   = tag_q[rd_set][w];
            row_host[w]  = host_q[rd_set][w];
            row_shr[w]   = shr_q[rd_set][w];
        end
    end
endmodule

// File: rtl/trk_lru.sv
module trk_lru #(
    parameter int SETS = 32,
    parameter int WAYS = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][WAY_W-1:0]  row_age,
    input  logic                        touch_en,
    input  logic [SET_W-1:0]            touch_set,
    input  logic [WAY_W-1:0]            touch_way
);
    // age 0 is most recent; each set always holds a permutation of ages
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_age[w] = age_q[rd_set][w];
        end
    end
endmodule

// File: rtl/trk_victim.sv
module trk_victim #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             row_valid,
    input  logic [WAYS-1:0]             row_prin,
    input  logic [WAYS-1:0][WAY_W-1:0]  row_age,
    input  logic                        ins_prin,
    output logic                        vic_found,
    output logic [WAY_W-1:0]            vic_way,
    output logic                        vic_valid,
    output logic                        vic_prin
);
    logic             inv_found, rep_found, pri_found;
    logic [WAY_W-1:0] inv_way, rep_way, pri_way;
    logic [WAY_W-1:0] rep_age, pri_age;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!row_valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        rep_found = 1'b0;
        rep_way   = '0;
        rep_age   = '0;
        pri_found = 1'b0;
        pri_way   = '0;
        pri_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (row_valid[w] && !row_prin[w] && (!rep_found || row_age[w] > rep_age)) begin
                rep_found = 1'b1;
                rep_way   = WAY_W'(w);
                rep_age   = row_age[w];
            end
            if (row_valid[w] && row_prin[w] && (!pri_found || row_age[w] > pri_age)) begin
                pri_found = 1'b1;
                pri_way   = WAY_W'(w);
                pri_age   = row_age[w];
            end
        end
    end

    always_comb begin
        vic_found = 1'b0;
        vic_way   = '0;
        vic_valid = 1'b0;
        vic_prin  = 1'b0;
        if (inv_found) begin
            vic_found = 1'b1;
            vic_way   = inv_way;
        end else if (rep_found) begin
            vic_found = 1'b1;
            vic_way   = rep_way;
            vic_valid = 1'b1;
        end else if (ins_prin && pri_found) begin
            vic_found = 1'b1;
            vic_way   = pri_way;
            vic_valid = 1'b1;
            vic_prin  = 1'b1;
        end
    end
endmodule

// File: rtl/trk_table.sv
module trk_table #(
    parameter int SETS  = 32,
    parameter int WAYS  = 8,
    parameter int TILES = 16,
    parameter int TAG_W = 22,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int HOST_W = $clog2(TILES),
    localparam int ADDR_W = TAG_W + SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_principal,
    input  logic [HOST_W-1:0] req_host,
    input  logic [TILES-1:0]  req_sharers,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_stored,
    output logic              rsp_principal,
    output logic [HOST_W-1:0] rsp_host,
    output logic [TILES-1:0]  rsp_sharers,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic [HOST_W-1:0] evict_host,
    output logic [TILES-1:0]  evict_sharers
);
    import trk_pkg::*;

    trk_state_e state_q, state_d;

    logic              op_ins_q, op_prin_q;
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  rtag_q;
    logic [HOST_W-1:0] host_q;
    logic [TILES-1:0]  shr_q;

    logic [WAYS-1:0]             row_valid, row_prin;
    logic [WAYS-1:0][TAG_W-1:0]  row_tag;
    logic [WAYS-1:0][HOST_W-1:0] row_host;
    logic [WAYS-1:0][TILES-1:0]  row_shr;
    logic [WAYS-1:0][WAY_W-1:0]  row_age;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             vic_found, vic_valid, vic_prin;
    logic [WAY_W-1:0] vic_way;
    logic             wr_en, touch_en;
    logic [WAY_W-1:0] wr_way;

    assign req_ready = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_op ? ST_INSERT : ST_LOOKUP;
            ST_LOOKUP: state_d = ST_DONE;
            ST_INSERT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_ins_q  <= 1'b0;
            op_prin_q <= 1'b0;
            set_q     <= '0;
            rtag_q    <= '0;
            host_q    <= '0;
            shr_q     <= '0;
        end else if (req_ready && req_valid) begin
            op_ins_q  <= req_op;
            op_prin_q <= req_principal;
            set_q     <= req_addr[SET_W-1:0];
            rtag_q    <= req_addr[ADDR_W-1:SET_W];
            host_q    <= req_host;
            shr_q     <= req_sharers;
        end
    end

    trk_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .HOST_W(HOST_W), .TILES(TILES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(set_q),
        .row_valid(row_valid), .row_prin(row_prin), .row_tag(row_tag),
        .row_host(row_host), .row_shr(row_shr),
        .wr_en(wr_en), .wr_set(set_q), .wr_way(wr_way), .wr_prin(op_prin_q),
        .wr_tag(rtag_q), .wr_host(host_q), .wr_shr(shr_q)
    );

    trk_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .rd_set(set_q), .row_age(row_age),
        .touch_en(touch_en), .touch_set(set_q), .touch_way(wr_way)
    );

    trk_victim #(.WAYS(WAYS)) u_victim (
        .row_valid(row_valid), .row_prin(row_prin), .row_age(row_age),
        .ins_prin(op_prin_q), .vic_found(vic_found), .vic_way(vic_way),
        .vic_valid(vic_valid), .vic_prin(vic_prin)
    );

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && row_valid[w] && row_tag[w] == rtag_q) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        touch_en = 1'b0;
        wr_way   = hit ? hit_way : vic_way;
        unique case (state_q)
            ST_LOOKUP: touch_en = hit;
            ST_INSERT: begin
                wr_en    = hit || vic_found;
                touch_en = hit || vic_found;
            end
            default: ;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_stored    <= 1'b0;
            rsp_principal <= 1'b0;
            rsp_host      <= '0;
            rsp_sharers   <= '0;
            evict_valid   <= 1'b0;
            evict_addr    <= '0;
            evict_host    <= '0;
            evict_sharers <= '0;
        end else begin
            rsp_valid   <= 1'b0;
            evict_valid <= 1'b0;
            unique case (state_q)
                ST_LOOKUP: begin
                    rsp_valid     <= 1'b1;
                    rsp_hit       <= hit;
                    rsp_stored    <= 1'b0;
                    rsp_principal <= hit && row_prin[hit_way];
                    rsp_host      <= hit ? row_host[hit_way] : '0;
                    rsp_sharers   <= hit ? row_shr[hit_way] : '0;
                end
                ST_INSERT: begin
                    rsp_valid     <= 1'b1;
                    rsp_hit       <= hit;
                    rsp_stored    <= hit || vic_found;
                    rsp_principal <= 1'b0;
                    rsp_host      <= '0;
                    rsp_sharers   <= '0;
                    evict_valid   <= !hit && vic_found && vic_valid && vic_prin;
                    evict_addr    <= {row_tag[vic_way], set_q};
                    evict_host    <= row_host[vic_way];
                    evict_sharers <= row_shr[vic_way];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trk_table_chk.sv
module trk_table_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_stored,
    input logic evict_valid,
    input logic op_ins,
    input logic op_prin
);
    // R1: response is a single-cycle pulse
    p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1: busy while the response is shown, ready right after
    p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    p_ready_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R1: a lookup neither stores nor evicts
    p_lookup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !op_ins) |-> (!rsp_stored && !evict_valid));

    // R5: a replicated insert never displaces a principal entry
    p_rep_no_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (op_ins && op_prin));

    // R4: an eviction comes with a stored, non-matching insert response
    p_evict_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (rsp_valid && rsp_stored && !rsp_hit));
endmodule

bind trk_table trk_table_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_stored(rsp_stored), .evict_valid(evict_valid),
    .op_ins(op_ins_q), .op_prin(op_prin_q)
);

// File: tb/test_trk_table.sv
module test_trk_table;
    localparam int TAG_W = 22;
    localparam int SET_W = 5;
    localparam int AW    = TAG_W + SET_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_principal = 1'b0;
    logic [3:0]    req_host = '0;
    logic [15:0]   req_sharers = '0;
    logic          rsp_valid, rsp_hit, rsp_stored, rsp_principal;
    logic [3:0]    rsp_host;
    logic [15:0]   rsp_sharers;
    logic          evict_valid;
    logic [AW-1:0] evict_addr;
    logic [3:0]    evict_host;
    logic [15:0]   evict_sharers;

    always #2 clk = ~clk;

    trk_table i_trk_table (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_principal(req_principal),
        .req_host(req_host), .req_sharers(req_sharers), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_stored(rsp_stored), .rsp_principal(rsp_principal),
        .rsp_host(rsp_host), .rsp_sharers(rsp_sharers), .evict_valid(evict_valid),
        .evict_addr(evict_addr), .evict_host(evict_host), .evict_sharers(evict_sharers)
    );

    typedef struct {
        string         tag;
        logic          ins;
        logic          hit;
        logic          prin;
        logic [3:0]    host;
        logic [15:0]   shr;
        logic          stored;
        logic          ev;
        logic [AW-1:0] ev_addr;
        logic [3:0]    ev_host;
        logic [15:0]   ev_shr;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return {TAG_W'(tag), SET_W'(set)};
    endfunction

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_hit == e.hit, e.tag, "hit", 64'(rsp_hit), 64'(e.hit));
                check(rsp_stored == e.stored, e.tag, "stored", 64'(rsp_stored), 64'(e.stored));
                check(evict_valid == e.ev, e.tag, "evict_valid", 64'(evict_valid), 64'(e.ev));
                if (!e.ins && e.hit) begin
                    check(rsp_principal == e.prin, e.tag, "class", 64'(rsp_principal), 64'(e.prin));
                    check(rsp_host == e.host, e.tag, "host", 64'(rsp_host), 64'(e.host));
                    check(rsp_sharers == e.shr, e.tag, "sharers", 64'(rsp_sharers), 64'(e.shr));
                end
                if (e.ev && evict_valid) begin
                    check(evict_addr == e.ev_addr, e.tag, "evict_addr", 64'(evict_addr), 64'(e.ev_addr));
                    check(evict_host == e.ev_host, e.tag, "evict_host", 64'(evict_host), 64'(e.ev_host));
                    check(evict_sharers == e.ev_shr, e.tag, "evict_sharers", 64'(evict_sharers), 64'(e.ev_shr));
                end
            end
        end
    end

    // driver
    task automatic drive(input logic op, input logic [AW-1:0] a, input logic p,
                         input logic [3:0] h, input logic [15:0] s, input exp_t e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid = 1'b1; req_op = op; req_addr = a;
        req_principal = p; req_host = h; req_sharers = s;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1", "ready while busy", 64'(req_ready), 64'd0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic look(input string r, input logic [AW-1:0] a, input logic hit,
                        input logic p, input logic [3:0] h, input logic [15:0] s);
        exp_t e;
        e = '{tag: r, ins: 1'b0, hit: hit, prin: p, host: h, shr: s, stored: 1'b0,
              ev: 1'b0, ev_addr: '0, ev_host: '0, ev_shr: '0};
        drive(1'b0, a, 1'b0, 4'd0, 16'd0, e);
    endtask

    task automatic ins(input string r, input logic [AW-1:0] a, input logic p,
                       input logic [3:0] h, input logic [15:0] s, input logic hit,
                       input logic stored, input logic ev, input logic [AW-1:0] ea,
                       input logic [3:0] eh, input logic [15:0] es);
        exp_t e;
        e = '{tag: r, ins: 1'b1, hit: hit, prin: 1'b0, host: '0, shr: '0, stored: stored,
              ev: ev, ev_addr: ea, ev_host: eh, ev_shr: es};
        drive(1'b1, a, p, h, s, e);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(evict_valid == 1'b0, "R9", "evict_valid after reset", 64'(evict_valid), 64'd0);
        look("R9", mk(22'h100, 3), 1'b0, 1'b0, 4'd0, 16'd0);

        // R2 fill set 3 with principal entries
        for (int i = 0; i < 8; i++)
            ins("R2", mk(22'h100 + i, 3), 1'b1, 4'(i), 16'(1) << i, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R1", mk(22'h100, 3), 1'b1, 1'b1, 4'd0, 16'h0001);   // refreshes T0 (R7)
        look("R1", mk(22'h1ff, 3), 1'b0, 1'b0, 4'd0, 16'd0);
        // R5 replicated insert into all-principal set is dropped
        ins("R5", mk(22'h200, 3), 1'b0, 4'd5, 16'd0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
        look("R5", mk(22'h200, 3), 1'b0, 1'b0, 4'd0, 16'd0);
        // R4 principal insert evicts LRU principal T1 (T0 was refreshed: R7)
        ins("R4", mk(22'h108, 3), 1'b1, 4'd8, 16'h0100, 1'b0, 1'b1, 1'b1,
            mk(22'h101, 3), 4'd1, 16'h0002);
        look("R4", mk(22'h101, 3), 1'b0, 1'b0, 4'd0, 16'd0);
        look("R7", mk(22'h100, 3), 1'b1, 1'b1, 4'd0, 16'h0001);
        // R8 in-place update
        ins("R8", mk(22'h102, 3), 1'b1, 4'd9, 16'hABCD, 1'b1, 1'b1, 1'b0, '0, '0, '0);
        look("R8", mk(22'h102, 3), 1'b1, 1'b1, 4'd9, 16'hABCD);
        look("R8", mk(22'h108, 3), 1'b1, 1'b1, 4'd8, 16'h0100);

        // set 5 mixed classes: A0, B0..B2, A1..A4
        ins("R2", mk(22'h300, 5), 1'b1, 4'd0, 16'h0011, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        for (int j = 0; j < 3; j++)
            ins("R2", mk(22'h400 + j, 5), 1'b0, 4'(8 + j), 16'd0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        for (int i = 1; i < 5; i++)
            ins("R2", mk(22'h300 + i, 5), 1'b1, 4'(i), 16'h0011 << i, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        // R3 principal insert takes LRU replicated B0, older A0 kept
        ins("R3", mk(22'h305, 5), 1'b1, 4'd5, 16'h0011 << 5, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R3", mk(22'h400, 5), 1'b0, 1'b0, 4'd0, 16'd0);
        look("R1", mk(22'h401, 5), 1'b1, 1'b0, 4'd9, 16'd0);      // refresh B1 (R7)
        // R6 replicated insert takes LRU replicated B2
        ins("R6", mk(22'h403, 5), 1'b0, 4'd11, 16'd0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R6", mk(22'h402, 5), 1'b0, 1'b0, 4'd0, 16'd0);
        look("R7", mk(22'h401, 5), 1'b1, 1'b0, 4'd9, 16'd0);
        look("R3", mk(22'h300, 5), 1'b1, 1'b1, 4'd0, 16'h0011);
        // R3 again: victim is B3 (B1 more recent)
        ins("R3", mk(22'h306, 5), 1'b1, 4'd6, 16'h0011 << 6, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R3", mk(22'h403, 5), 1'b0, 1'b0, 4'd0, 16'd0);
        look("R7", mk(22'h401, 5), 1'b1, 1'b0, 4'd9, 16'd0);
        ins("R3", mk(22'h307, 5), 1'b1, 4'd7, 16'h0011 << 7, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R3", mk(22'h401, 5), 1'b0, 1'b0, 4'd0, 16'd0);
        // R4 all principal now; LRU principal is A1
        ins("R4", mk(22'h308, 5), 1'b1, 4'd8, 16'h1100, 1'b0, 1'b1, 1'b1,
            mk(22'h301, 5), 4'd1, 16'h0022);
        look("R4", mk(22'h301, 5), 1'b0, 1'b0, 4'd0, 16'd0);

        // R2 replicated insert into empty set 0
        ins("R2", mk(22'h500, 0), 1'b0, 4'd7, 16'd0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        look("R2", mk(22'h500, 0), 1'b1, 1'b0, 4'd7, 16'd0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1", "missing responses", 64'(exp_q.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule